// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line. A one-entry holding register sits in front of the shift register. Software writes a byte into the holding register through a single-cycle write strobe. On a baud tick, the shifter takes that byte and sends a frame on `txd`. A frame is one start bit, eight data bits and one stop bit. While the frame is on the line, the holding register is free to accept the next byte. A byte that is waiting when the current frame ends is sent straight after it, with no idle bit in between.

Two interrupt pulses pace the software. `irq_buf_empty` fires when the holding register hands its byte to the shifter. A reload routine can use it and still have a whole frame time to write the next byte. `irq_tx_empty` fires when the stop bit starts on the line, which is one bit time before the frame ends. It says that the data field has been fully sent, so it is the indication to use after the last byte of a block. The `buf_full` output tells software whether the holding register is occupied.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_full` is 0 and both interrupt outputs are 0.
- R2: A write strobe while `buf_full` is 0 sets `buf_full` in the next cycle. `txd` stays at its idle level 1 until a baud tick arrives.
- R3: A frame on `txd` is a start bit 0, then eight data bits with bit 0 first, then a stop bit 1. Each bit lasts from one baud tick to the next. `txd` changes only in the cycle that follows a clock edge at which `baud_tick` was high.
- R4: When the shifter is idle and the holding register is full, the next baud tick moves the byte into the shifter. In the following cycle the start bit is on `txd`, `buf_full` is 0, and `irq_buf_empty` is high for exactly one cycle.
- R5: `irq_tx_empty` is high for exactly one cycle, in the first cycle that the stop bit is driven.
- R6: A write strobe while `buf_full` is 1 is ignored. The byte already held is the one that is sent.
- R7: The holding register accepts a write while a frame is being shifted. If it is full when the stop bit's baud tick ends, that same tick starts the next frame's start bit. `irq_buf_empty` pulses again, and no idle bit appears.
- R8: If the holding register is empty when the stop bit ends, `txd` returns to 1. No further frame or interrupt occurs until a new byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| baud_tick | input | 1 | Single-cycle pulse once per bit time |
| txd | output | 1 | Serial output line |
| buf_full | output | 1 | Holding register occupied |
| irq_buf_empty | output | 1 | Pulse when the holding register hands off to the shifter |
| irq_tx_empty | output | 1 | Pulse when the stop bit begins |

## Verification
The bench targets the frame-to-frame seam. If a design reloads the shifter only from idle, an extra 1 bit appears between back-to-back frames. If a design frees the holding register late, the start bit never follows the stop bit. A second write to a full holding register is checked by reading the sent bits: a design that overwrites the register sends the wrong byte. The interrupt pulses are checked in their exact cycle and again one cycle later, which catches a transmit-empty that fires after the stop bit rather than at its start, and a pulse that stays high.

// File: rtl/tx_pkg.sv
// Package: shared types for the double-buffered serial transmitter.
// Assumes: one start bit and one stop bit per frame.
package tx_pkg;
    // Line phase of the frame shifter.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } phase_e;
endpackage

// File: rtl/hold_buf.sv
// Module: hold_buf
// One-entry holding register in front of the shifter. A write is accepted only
// while the register is empty. A take from the shifter empties it.
// Assumes: take is asserted only while full is high.
module hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Occupancy flag and stored byte; a write to a full register is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !take) |=> (full && $stable(data)));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && wr_en) |=> full);
endmodule

// File: rtl/frame_shifter.sv
// Module: frame_shifter
// Sends start, data (LSB first) and stop bits, one bit per baud tick. It
// reloads from the holding register when idle or at the end of the stop bit.
// Assumes: baud_tick is a single-cycle pulse.
module frame_shifter
    import tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    output logic              take,
    output logic              txd,
    output logic              irq_buf_empty,
    output logic              irq_tx_empty
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    phase_e            phase;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              last_data;

    // Hand-off point: a tick while idle or at the end of the stop bit.
    assign take      = baud_tick && buf_full && (phase == PH_IDLE || phase == PH_STOP);
    assign last_data = (phase == PH_DATA) && (cnt == LAST_IDX);

    // Phase sequencing, data shifting and the registered interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase         <= PH_IDLE;
            shreg         <= '0;
            cnt           <= '0;
            irq_buf_empty <= 1'b0;
            irq_tx_empty  <= 1'b0;
        end else begin
            irq_buf_empty <= take;
            irq_tx_empty  <= baud_tick && last_data;
            if (take) begin
                shreg <= buf_data;
                cnt   <= '0;
                phase <= PH_START;
            end else if (baud_tick) begin
                unique case (phase)
                    PH_IDLE:  phase <= PH_IDLE;
                    PH_START: phase <= PH_DATA;
                    PH_DATA: begin
                        if (last_data) begin
                            phase <= PH_STOP;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            shreg <= shreg >> 1;
                        end
                    end
                    PH_STOP:  phase <= PH_IDLE;
                    default:  phase <= PH_IDLE;
                endcase
            end
        end
    end

    // Line level for the current phase.
    always_comb begin
        unique case (phase)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    // R5
    tx_empty_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |-> (txd == 1'b1 && phase == PH_STOP));

    // R5
    tx_empty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |=> !irq_tx_empty);

    // R4
    buf_empty_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_buf_empty |-> (txd == 1'b0));

    // R3
    line_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));
endmodule

// File: rtl/dbuf_serial_tx.sv
// Module: dbuf_serial_tx
// Top of the double-buffered serial transmitter: a holding register feeding a
// frame shifter, with buffer-empty and transmit-empty interrupt pulses.
// Assumes: baud_tick comes from an external rate generator in this clock domain.
module dbuf_serial_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              txd,
    output logic              buf_full,
    output logic              irq_buf_empty,
    output logic              irq_tx_empty
);
    logic              take;
    logic [DATA_W-1:0] held;

    hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (buf_full),
        .data    (held)
    );

    frame_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk           (clk),
        .rst_n         (rst_n),
        .baud_tick     (baud_tick),
        .buf_full      (buf_full),
        .buf_data      (held),
        .take          (take),
        .txd           (txd),
        .irq_buf_empty (irq_buf_empty),
        .irq_tx_empty  (irq_tx_empty)
    );

    // R4
    handoff_frees_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_buf_empty |-> !buf_full);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (txd && !buf_full && !irq_buf_empty && !irq_tx_empty));
endmodule

// File: tb/dbuf_serial_tx_test.sv
// Directed bench for dbuf_serial_tx: one task per scenario.
module dbuf_serial_tx_test;
    localparam time CLK_P = 5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       txd, buf_full, irq_buf_empty, irq_tx_empty;
    int         n_checks = 0;
    int         n_errs = 0;
    bit         done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    dbuf_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .txd(txd), .buf_full(buf_full),
        .irq_buf_empty(irq_buf_empty), .irq_tx_empty(irq_tx_empty)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One baud tick; returns just after the edge that consumed it.
    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    // After the start bit is on the line: check data bits and stop bit.
    // Writes nxt part-way through the frame when do_next is set (R7).
    task automatic frame_body(input logic [7:0] exp, input bit do_next,
                              input logic [7:0] nxt, input string tag);
        for (int i = 0; i < 8; i++) begin
            tick();
            check({"R3 data bit ", tag}, txd, exp[i]);
            if (i == 3 && do_next) begin
                write_byte(nxt);
                check("R7 buffer refilled during frame", buf_full, 1);
            end
        end
        tick();
        check("R3 stop bit", txd, 1);
        check("R5 tx_empty at stop start", irq_tx_empty, 1);
        @(negedge clk);
        check("R5 tx_empty single cycle", irq_tx_empty, 0);
        check("R3 stop bit held", txd, 1);
    endtask

    task automatic t_reset();
        check("R1 txd idle", txd, 1);
        check("R1 buf_full clear", buf_full, 0);
        check("R1 irq_buf_empty low", irq_buf_empty, 0);
        check("R1 irq_tx_empty low", irq_tx_empty, 0);
    endtask

    task automatic t_single();
        write_byte(8'hA5);
        check("R2 buf_full after write", buf_full, 1);
        repeat (3) @(negedge clk);
        check("R2 line idle without tick", txd, 1);
        tick();
        check("R4 start bit", txd, 0);
        check("R4 buf_empty pulse", irq_buf_empty, 1);
        check("R4 buffer freed", buf_full, 0);
        @(negedge clk);
        check("R4 buf_empty single cycle", irq_buf_empty, 0);
        frame_body(8'hA5, 1'b0, 8'h00, "A5");
        tick();
        check("R8 line idle after frame", txd, 1);
        check("R8 no buf_empty", irq_buf_empty, 0);
        repeat (2) tick();
        check("R8 stays idle", txd, 1);
        check("R8 no tx_empty", irq_tx_empty, 0);
    endtask

    task automatic t_ignore_full();
        write_byte(8'h3C);
        write_byte(8'hFF);
        check("R6 still full", buf_full, 1);
        tick();
        check("R4 start bit", txd, 0);
        frame_body(8'h3C, 1'b0, 8'h00, "held 3C");
        tick();
        check("R6 no second frame", txd, 1);
        check("R6 buffer empty", buf_full, 0);
    endtask

    task automatic t_back_to_back();
        write_byte(8'h81);
        tick();
        check("R4 start bit", txd, 0);
        frame_body(8'h81, 1'b1, 8'h5E, "81");
        tick();
        check("R7 start follows stop", txd, 0);
        check("R7 buf_empty on chain", irq_buf_empty, 1);
        check("R7 buffer freed", buf_full, 0);
        frame_body(8'h5E, 1'b0, 8'h00, "5E");
        tick();
        check("R8 idle after chain", txd, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_ignore_full();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule